// File: doc/BRIEF.md
# Quad-Pumped Data Receiver with Per-Group Polarity Restore

This block receives a 64-line data bus that carries four transfers in every bus clock period and restores the true data. The lines are split into four 16-bit groups. Each group has its own pair of sample enables, one for the positive-phase strobe fall and one for the negative-phase strobe fall, and its own polarity flag. Each group is decoded on its own. The lines are active low unless the group's flag marks the transfer as inverted, in which case the levels are taken as they are.

The strobe edges arrive as single-cycle sample-enable pulses in a capture clock that runs at four times the bus clock. The two clocks are ratio-locked, and their edges are offset from each other. The capture clock splits time into bus periods of four cycles each, counted from reset release. A beat counts only while the sender's data-ready is high. A group accepts its beats alternately from its positive-phase and negative-phase enable, starting with the positive phase. At the end of each period the four group counts are compared. A complete four-beat transfer is assembled into a 256-bit word and handed to the bus-clock domain through a two-entry buffer. A mismatch between groups raises an error pulse.

Top module: `qp_rx_top`

## Requirements
- R1: Group n is made of lines [16n+15:16n] and is paired with sample enables pos_smp[n] and neg_smp[n] and with flag grp_flip[n]. Beat k of group n appears at word_out[64k+16n+15 : 64k+16n].
- R2: For each beat, the restored value is the line levels as driven when the group's grp_flip bit is 1. It is the bitwise inverse of the line levels when that bit is 0.
- R3: A group takes its beats in alternation. A beat with an even index (0, 2) is taken only from pos_smp, and a beat with an odd index (1, 3) only from neg_smp. A pulse on the enable that is not expected is ignored. A group's count rises by at most one per capture cycle.
- R4: A beat is taken only in a capture cycle in which xfer_rdy is high. An enable pulse while xfer_rdy is low is discarded and leaves the group's count unchanged.
- R5: A bus period is four capture cycles, counted from reset release, and the group counts clear at each period end. If all four groups hold four beats at the end, a word is produced. If the counts differ, beat_err pulses for one capture cycle and no word is produced. Equal counts below four are dropped without an error.
- R6: Each completed word reaches word_out through a two-entry buffer. word_vld is high for exactly one bus-clock cycle per word, and words come out in order. word_out keeps its value in every cycle in which word_vld is low.
- R7: While reset is held, word_vld is 0, beat_err is 0 and word_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_q | input | 1 | Capture clock, four times the bus clock |
| clk_bus | input | 1 | Bus clock, ratio-locked to clk_q with offset edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_dn | input | 64 | Data lines as driven on the bus |
| grp_flip | input | 4 | Per-group polarity flag for the current beat, 1 = lines carry true levels |
| pos_smp | input | 4 | Per-group pulse marking a positive-phase strobe fall |
| neg_smp | input | 4 | Per-group pulse marking a negative-phase strobe fall |
| xfer_rdy | input | 1 | Sender's data-ready qualifier for the current beat |
| word_out | output | 256 | Assembled four-beat word, bus-clock domain |
| word_vld | output | 1 | One-cycle pulse per delivered word, bus-clock domain |
| beat_err | output | 1 | One-cycle pulse in the capture domain when the group counts disagree |

## Verification
The bench uses the default parameters: four groups of 16 lines and four beats per bus period. With these, every one of the 256 output bit positions is reached, and both polarities can be mixed within one transfer. The small beat count keeps the ignored-enable cases short. Wrong-phase pulses, missing pulses and pulses without data-ready each leave one group, or all groups, short within a single period. Back-to-back transfers in consecutive periods keep both buffer entries in use.

// File: rtl/qp_rx_pkg.sv
package qp_rx_pkg;
  localparam int DEF_GROUPS = 4;
  localparam int DEF_GRP_W  = 16;
  localparam int DEF_BEATS  = 4;

  typedef enum logic {
    PH_POS = 1'b0,
    PH_NEG = 1'b1
  } strobe_ph_e;
endpackage

// File: rtl/qp_rx_rst_sync.sv
module qp_rx_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      s1_q      <= 1'b0;
      rst_out_n <= 1'b0;
    end else begin
      s1_q      <= 1'b1;
      rst_out_n <= s1_q;
    end
  end
endmodule

// File: rtl/qp_rx_lane.sv
module qp_rx_lane
  import qp_rx_pkg::*;
#(
  parameter int GRP_W = DEF_GRP_W,
  parameter int BEATS = DEF_BEATS,
  parameter int PH_W  = $clog2(BEATS),
  parameter int CNT_W = PH_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GRP_W-1:0]         line_n,
  input  logic                     flip,
  input  logic                     pos_pulse,
  input  logic                     neg_pulse,
  input  logic                     rdy,
  input  logic                     clr,
  output logic [CNT_W-1:0]         cnt_q,
  output logic [CNT_W-1:0]         cnt_eval,
  output logic [BEATS*GRP_W-1:0]   beats_nx
);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(BEATS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [BEATS*GRP_W-1:0] beats_q;
  logic [CNT_W-1:0]       cnt_d;
  logic [GRP_W-1:0]       true_v;
  strobe_ph_e             want_ph;
  logic                   hit;

  // next-state logic
  always_comb begin
    want_ph  = cnt_q[0] ? PH_NEG : PH_POS;
    hit      = rdy & ((want_ph == PH_POS) ? pos_pulse : neg_pulse);
    true_v   = flip ? line_n : ~line_n;
    beats_nx = beats_q;
    if (hit && (cnt_q < FULL))
      beats_nx[int'(cnt_q[PH_W-1:0]) * GRP_W +: GRP_W] = true_v;
    cnt_eval = cnt_q;
    if (hit && (cnt_q != CNT_MAX))
      cnt_eval = cnt_q + 1'b1;
    cnt_d = clr ? '0 : cnt_eval;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      beats_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (hit) beats_q <= beats_nx;
    end
  end
endmodule

// File: rtl/qp_rx_frame.sv
module qp_rx_frame #(
  parameter int GROUPS = 4,
  parameter int BEATS  = 4,
  parameter int PH_W   = $clog2(BEATS),
  parameter int CNT_W  = PH_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [GROUPS-1:0][CNT_W-1:0] cnt_eval,
  output logic                         clr,
  output logic                         push,
  output logic [PH_W-1:0]              ph_q,
  output logic                         err_q
);
  localparam logic [PH_W-1:0]  LAST = PH_W'(BEATS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BEATS);

  logic [PH_W-1:0] ph_d;
  logic            err_d;
  logic            all_eq;
  logic            last;

  // next-state logic
  always_comb begin
    last   = (ph_q == LAST);
    ph_d   = ph_q + 1'b1;
    all_eq = 1'b1;
    for (int g = 1; g < GROUPS; g++)
      if (cnt_eval[g] != cnt_eval[0]) all_eq = 1'b0;
    clr   = last;
    push  = last && all_eq && (cnt_eval[0] == FULL);
    err_d = last && !all_eq;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      err_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/qp_rx_xfer.sv
module qp_rx_xfer #(
  parameter int WORD_W = 256
) (
  input  logic              clk_w,
  input  logic              rst_w_n,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clk_r,
  input  logic              rst_r_n,
  output logic [WORD_W-1:0] rdata_q,
  output logic              rvld_q,
  output logic              rsel_q
);
  logic [WORD_W-1:0] ent0_q, ent1_q, ent0_d, ent1_d;
  logic              wsel_q, wsel_d;
  logic              wsel_s_q;
  logic [WORD_W-1:0] rdata_d;
  logic              rsel_d, rvld_d, rd_go;

  // write side, capture clock
  always_comb begin
    ent0_d = ent0_q;
    ent1_d = ent1_q;
    wsel_d = wsel_q;
    if (push) begin
      if (wsel_q) ent1_d = wdata;
      else        ent0_d = wdata;
      wsel_d = ~wsel_q;
    end
  end

  always_ff @(posedge clk_w or negedge rst_w_n) begin
    if (!rst_w_n) begin
      ent0_q <= '0;
      ent1_q <= '0;
      wsel_q <= 1'b0;
    end else begin
      ent0_q <= ent0_d;
      ent1_q <= ent1_d;
      wsel_q <= wsel_d;
    end
  end

  // read side, bus clock (clocks are ratio-locked: one retiming stage)
  always_comb begin
    rd_go   = (wsel_s_q != rsel_q);
    rdata_d = rdata_q;
    rsel_d  = rsel_q;
    rvld_d  = rd_go;
    if (rd_go) begin
      rdata_d = rsel_q ? ent1_q : ent0_q;
      rsel_d  = ~rsel_q;
    end
  end

  always_ff @(posedge clk_r or negedge rst_r_n) begin
    if (!rst_r_n) begin
      wsel_s_q <= 1'b0;
      rsel_q   <= 1'b0;
      rdata_q  <= '0;
      rvld_q   <= 1'b0;
    end else begin
      wsel_s_q <= wsel_q;
      rsel_q   <= rsel_d;
      rdata_q  <= rdata_d;
      rvld_q   <= rvld_d;
    end
  end
endmodule

// File: rtl/qp_rx_top.sv
module qp_rx_top
  import qp_rx_pkg::*;
#(
  parameter int GROUPS = DEF_GROUPS,
  parameter int GRP_W  = DEF_GRP_W,
  parameter int BEATS  = DEF_BEATS
) (
  input  logic                             clk_q,
  input  logic                             clk_bus,
  input  logic                             rst_n,
  input  logic [GROUPS*GRP_W-1:0]          bus_dn,
  input  logic [GROUPS-1:0]                grp_flip,
  input  logic [GROUPS-1:0]                pos_smp,
  input  logic [GROUPS-1:0]                neg_smp,
  input  logic                             xfer_rdy,
  output logic [GROUPS*GRP_W*BEATS-1:0]    word_out,
  output logic                             word_vld,
  output logic                             beat_err
);
  localparam int BUS_W  = GROUPS * GRP_W;
  localparam int WORD_W = BUS_W * BEATS;
  localparam int PH_W   = $clog2(BEATS);
  localparam int CNT_W  = PH_W + 1;

  logic                         rst_f_n, rst_b_n;
  logic                         frame_clr, frame_push;
  logic [PH_W-1:0]              frame_ph;
  logic [GROUPS-1:0][CNT_W-1:0] lane_cnt, lane_eval;
  logic [BEATS*GRP_W-1:0]       lane_beats [GROUPS];
  logic [WORD_W-1:0]            asm_word;
  logic                         rd_sel;

  qp_rx_rst_sync u_rst_f (.clk(clk_q),   .rst_in_n(rst_n), .rst_out_n(rst_f_n));
  qp_rx_rst_sync u_rst_b (.clk(clk_bus), .rst_in_n(rst_n), .rst_out_n(rst_b_n));

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    qp_rx_lane #(.GRP_W(GRP_W), .BEATS(BEATS), .PH_W(PH_W), .CNT_W(CNT_W)) u_lane (
      .clk       (clk_q),
      .rst_n     (rst_f_n),
      .line_n    (bus_dn[g*GRP_W +: GRP_W]),
      .flip      (grp_flip[g]),
      .pos_pulse (pos_smp[g]),
      .neg_pulse (neg_smp[g]),
      .rdy       (xfer_rdy),
      .clr       (frame_clr),
      .cnt_q     (lane_cnt[g]),
      .cnt_eval  (lane_eval[g]),
      .beats_nx  (lane_beats[g])
    );
    for (genvar k = 0; k < BEATS; k++) begin : g_beat
      assign asm_word[k*BUS_W + g*GRP_W +: GRP_W] = lane_beats[g][k*GRP_W +: GRP_W];
    end
  end

  qp_rx_frame #(.GROUPS(GROUPS), .BEATS(BEATS), .PH_W(PH_W), .CNT_W(CNT_W)) u_frame (
    .clk      (clk_q),
    .rst_n    (rst_f_n),
    .cnt_eval (lane_eval),
    .clr      (frame_clr),
    .push     (frame_push),
    .ph_q     (frame_ph),
    .err_q    (beat_err)
  );

  qp_rx_xfer #(.WORD_W(WORD_W)) u_xfer (
    .clk_w   (clk_q),
    .rst_w_n (rst_f_n),
    .push    (frame_push),
    .wdata   (asm_word),
    .clk_r   (clk_bus),
    .rst_r_n (rst_b_n),
    .rdata_q (word_out),
    .rvld_q  (word_vld),
    .rsel_q  (rd_sel)
  );
endmodule

// File: rtl/qp_rx_chk.sv
module qp_rx_chk #(
  parameter int GROUPS = 4,
  parameter int BEATS  = 4,
  parameter int WORD_W = 256,
  parameter int PH_W   = 2,
  parameter int CNT_W  = 3
) (
  input logic                         clk_q,
  input logic                         clk_bus,
  input logic                         rst_f_n,
  input logic                         rst_b_n,
  input logic [PH_W-1:0]              ph,
  input logic [GROUPS-1:0][CNT_W-1:0] cnt_q,
  input logic                         xfer_rdy,
  input logic                         beat_err,
  input logic                         word_vld,
  input logic [WORD_W-1:0]            word_out,
  input logic                         rsel
);
  localparam logic [PH_W-1:0] LAST = PH_W'(BEATS - 1);

  // R5: counts start empty in the first capture cycle of every bus period
  assert_cnt_clear_R5: assert property (@(posedge clk_q) disable iff (!rst_f_n)
    (ph == '0) |-> (cnt_q == '0));

  // R5: the error pulse follows a period end
  assert_err_at_end_R5: assert property (@(posedge clk_q) disable iff (!rst_f_n)
    beat_err |-> (ph == '0));

  // R4: no data-ready, no count change inside a period
  assert_rdy_gate_R4: assert property (@(posedge clk_q) disable iff (!rst_f_n)
    (!xfer_rdy && (ph != LAST)) |=> (cnt_q == $past(cnt_q)));

  // R3: each group advances by at most one beat per capture cycle
  for (genvar g = 0; g < GROUPS; g++) begin : g_step
    assert_step_R3: assert property (@(posedge clk_q) disable iff (!rst_f_n)
      (ph != LAST) |=> ((cnt_q[g] == $past(cnt_q[g])) ||
                        (cnt_q[g] == $past(cnt_q[g]) + 1'b1)));
  end

  // R6: output word holds while no valid is shown
  assert_out_hold_R6: assert property (@(posedge clk_bus) disable iff (!rst_b_n)
    !word_vld |-> $stable(word_out));

  // R6: every valid consumes one buffer entry
  assert_vld_moves_R6: assert property (@(posedge clk_bus) disable iff (!rst_b_n)
    word_vld |-> (rsel != $past(rsel)));
endmodule

bind qp_rx_top qp_rx_chk #(
  .GROUPS (GROUPS),
  .BEATS  (BEATS),
  .WORD_W (WORD_W),
  .PH_W   (PH_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_q    (clk_q),
  .clk_bus  (clk_bus),
  .rst_f_n  (rst_f_n),
  .rst_b_n  (rst_b_n),
  .ph       (frame_ph),
  .cnt_q    (lane_cnt),
  .xfer_rdy (xfer_rdy),
  .beat_err (beat_err),
  .word_vld (word_vld),
  .word_out (word_out),
  .rsel     (rd_sel)
);

// File: tb/qp_rx_top_test.sv
module qp_rx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int GROUPS = 4;
  localparam int GRP_W  = 16;
  localparam int BEATS  = 4;
  localparam int BUS_W  = GROUPS * GRP_W;
  localparam int WORD_W = BUS_W * BEATS;

  logic              clk_q = 1'b0;
  logic              clk_bus = 1'b0;
  logic              rst_n = 1'b0;
  logic [BUS_W-1:0]  bus_dn = '0;
  logic [GROUPS-1:0] grp_flip = '0;
  logic [GROUPS-1:0] pos_smp = '0;
  logic [GROUPS-1:0] neg_smp = '0;
  logic              xfer_rdy = 1'b0;
  logic [WORD_W-1:0] word_out;
  logic              word_vld;
  logic              beat_err;

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  int err_exp = 0;
  int words_seen = 0;
  int words_exp = 0;
  logic [WORD_W-1:0] exp_q [$];

  logic [GRP_W-1:0] tv [BEATS][GROUPS];
  logic             fl [BEATS][GROUPS];
  logic             ps [BEATS][GROUPS];
  logic             ns [BEATS][GROUPS];
  logic             rd [BEATS];

  qp_rx_top #(.GROUPS(GROUPS), .GRP_W(GRP_W), .BEATS(BEATS)) uut (
    .clk_q(clk_q), .clk_bus(clk_bus), .rst_n(rst_n), .bus_dn(bus_dn),
    .grp_flip(grp_flip), .pos_smp(pos_smp), .neg_smp(neg_smp),
    .xfer_rdy(xfer_rdy), .word_out(word_out), .word_vld(word_vld),
    .beat_err(beat_err)
  );

  always #(CLK_PERIOD/2) clk_q = ~clk_q;

  initial begin
    #(CLK_PERIOD/2 + 2);
    clk_bus = 1'b1;
    forever #(2*CLK_PERIOD) clk_bus = ~clk_bus;
  end

  task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fmode 0: hashed polarity per beat, 1: all flagged, 2: none flagged
  task automatic fill(input int seed, input int fmode);
    for (int k = 0; k < BEATS; k++) begin
      rd[k] = 1'b1;
      for (int g = 0; g < GROUPS; g++) begin
        tv[k][g] = GRP_W'((seed * 40503 + k * 4099 + g * 613) ^ (seed << (g + 3)));
        fl[k][g] = (fmode == 1) ? 1'b1 : (fmode == 2) ? 1'b0 : tv[k][g][5];
        ps[k][g] = (k % 2 == 0);
        ns[k][g] = (k % 2 == 1);
      end
    end
  endtask

  // driver: one bus period = four capture-cycle slots
  task automatic drive_frame(input bit exp_word, input int exp_e);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < BEATS; k++) begin
      @(negedge clk_q);
      for (int g = 0; g < GROUPS; g++) begin
        bus_dn[g*GRP_W +: GRP_W] = fl[k][g] ? tv[k][g] : ~tv[k][g];
        grp_flip[g] = fl[k][g];
        pos_smp[g]  = ps[k][g];
        neg_smp[g]  = ns[k][g];
        w[k*BUS_W + g*GRP_W +: GRP_W] = tv[k][g];
      end
      xfer_rdy = rd[k];
    end
    if (exp_word) begin
      exp_q.push_back(w);
      words_exp++;
    end
    err_exp += exp_e;
  endtask

  task automatic idle_frame();
    for (int k = 0; k < BEATS; k++) begin
      rd[k] = 1'b0;
      for (int g = 0; g < GROUPS; g++) begin
        tv[k][g] = '0; fl[k][g] = 1'b0; ps[k][g] = 1'b0; ns[k][g] = 1'b0;
      end
    end
    drive_frame(1'b0, 0);
  endtask

  // monitor: pop expected words as the design delivers them
  always @(negedge clk_bus) begin
    if (rst_n && word_vld) begin
      if (exp_q.size() == 0) begin
        chk("R6 valid without pending word", 1, 0);
      end else begin
        chk("R1 R2 R3 R6 delivered word", word_out, exp_q.pop_front());
        words_seen++;
      end
    end
  end

  always @(negedge clk_q) if (rst_n && beat_err) err_seen++;

  initial begin
    #(CLK_PERIOD * 40000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_q);
    @(negedge clk_q);
    chk("R7 word_vld in reset", WORD_W'(word_vld), '0);
    chk("R7 beat_err in reset", WORD_W'(beat_err), '0);
    chk("R7 word_out in reset", word_out, '0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk_q);

    idle_frame();
    idle_frame();

    // R1 R2 R3 R6: back-to-back transfers with mixed, all-set and all-clear polarity
    fill(1, 0);  drive_frame(1'b1, 0);
    fill(2, 0);  drive_frame(1'b1, 0);
    fill(3, 1);  drive_frame(1'b1, 0);
    fill(4, 2);  drive_frame(1'b1, 0);
    fill(5, 0);  drive_frame(1'b1, 0);
    idle_frame();
    chk("R5 no error on complete transfers", WORD_W'(err_seen), WORD_W'(err_exp));

    // R4: data-ready low on beat 2 -> all groups short alike, no word, no error
    fill(6, 0); rd[2] = 1'b0; drive_frame(1'b0, 0);
    idle_frame();
    chk("R4 beat without data-ready discarded", WORD_W'(err_seen), WORD_W'(err_exp));

    // R3: group 2 gets positive-phase pulse where negative expected -> short -> error
    fill(7, 0); ps[1][2] = 1'b1; ns[1][2] = 1'b0; drive_frame(1'b0, 1);
    idle_frame();
    chk("R3 wrong-phase pulse ignored, R5 error", WORD_W'(err_seen), WORD_W'(err_exp));

    // R5: group 0 misses beat 2 -> counts differ -> error, no word
    fill(8, 0); ps[2][0] = 1'b0; drive_frame(1'b0, 1);
    idle_frame();
    chk("R5 missing beat raises error", WORD_W'(err_seen), WORD_W'(err_exp));

    // R3: both enables high every beat -> only expected one counts -> word
    fill(9, 0);
    for (int k = 0; k < BEATS; k++)
      for (int g = 0; g < GROUPS; g++) begin ps[k][g] = 1'b1; ns[k][g] = 1'b1; end
    drive_frame(1'b1, 0);

    // R5: counts cleared after errors, normal transfer recovers
    fill(10, 0); drive_frame(1'b1, 0);
    fill(11, 1); drive_frame(1'b1, 0);

    repeat (4) idle_frame();
    chk("R5 error count at end", WORD_W'(err_seen), WORD_W'(err_exp));
    chk("R6 one valid per transfer", WORD_W'(words_seen), WORD_W'(words_exp));
    chk("R6 no pending words", WORD_W'(exp_q.size()), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule